// File: doc/BRIEF.md
# Enhanced Factory Program Sequencer

This block steers a streamed factory-programming mode for a flash command interface. A setup write, followed by a confirm write, starts the mode. The setup write also captures the block address it carries as the mode's home block. From then on no write is decoded as a command. A write that hits the home block hands its word to the programmer with a one-cycle data-valid pulse. A write elsewhere that carries all ones requests an exit. Any other write elsewhere is dropped.

Inside the mode the sequencer moves between a busy phase and a verify phase, paced by a completion signal from the program/erase controller. Completion in the busy phase leads to verify. A new home-block word arriving during verify sends the sequencer back to busy. Completion in verify after an exit request returns it to ready. Entry is refused while the status bit SR0 is 1. In that case the sequencer stays ready and raises an error flag.

Top module: `efp_seq`

## Requirements
- R1: After reset `state_o` is 0 (ready) and `dv_o`, `exit_o` and `err_o` are 0.
- R2: In ready, a write of the setup code 0x0030 with `sr0` at 0 moves `state_o` to 1 (setup) on the next cycle and captures `blk_addr` as the home block. A later setup replaces the captured home block.
- R3: In ready, a write of the setup code with `sr0` at 1 leaves `state_o` at 0 and sets `err_o`. `err_o` stays set until the next accepted setup clears it.
- R4: In setup, a write of the confirm code 0x00D0 moves `state_o` to 2 (busy). Any other write in setup returns `state_o` to 0 and sets `err_o`.
- R5: In busy (2) or verify (3), a write whose `blk_addr` equals the home block gives `dv_o` high for the following cycle, with `pdata_o` equal to the written word. This holds even when the word equals the setup or confirm code.
- R6: In busy or verify, a write to another block whose data is not 0xFFFF is ignored. It produces no `dv_o`, and `state_o` and `exit_o` are unchanged.
- R7: In busy or verify, a write to another block with data 0xFFFF sets `exit_o` on the next cycle and produces no `dv_o`.
- R8: In busy, `pec_done` moves `state_o` to 3 (verify).
- R9: In verify, a home-block write moves `state_o` back to 2. When `pec_done` is high in the same cycle, the write takes priority.
- R10: In verify, `pec_done` returns `state_o` to 0 and clears `exit_o` when an exit is pending or arrives in the same cycle. Without an exit, `state_o` stays at 3.
- R11: `pec_done` has no effect in ready or setup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | DATA_W (16) | Write data word |
| blk_addr | input | ADDR_W (8) | Block address of the write |
| sr0 | input | 1 | Status bit that must be 0 for entry |
| pec_done | input | 1 | Program/erase controller completion |
| state_o | output | 2 | 0 ready, 1 setup, 2 busy, 3 verify |
| dv_o | output | 1 | Data-valid pulse toward the programmer |
| pdata_o | output | DATA_W (16) | Word handed to the programmer |
| exit_o | output | 1 | Exit requested, held until ready |
| err_o | output | 1 | Entry refused or bad confirm |

## Verification
Two collisions can happen in the same cycle. A home-block data write can coincide with controller completion in verify. An exit write can also coincide with completion in verify. The bench raises `wr_en` and `pec_done` in the same cycle for each case. In the first case it expects busy together with a data-valid pulse carrying the word. In the second it expects ready with the exit flag already cleared. The same completion without any write is also applied in verify, to show that the sequencer stays in verify.

// File: rtl/efp_pkg.sv
package efp_pkg;
  typedef enum logic [1:0] {
    ST_READY  = 2'd0,
    ST_SETUP  = 2'd1,
    ST_BUSY   = 2'd2,
    ST_VERIFY = 2'd3
  } efp_state_t;
endpackage

// File: rtl/efp_rst_sync.sv
module efp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/efp_decode.sv
module efp_decode #(
  parameter int          ADDR_W       = 8,
  parameter int          DATA_W       = 16,
  parameter logic [15:0] SETUP_CODE   = 16'h0030,
  parameter logic [15:0] CONFIRM_CODE = 16'h00D0
) (
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] blk_addr,
  input  logic [ADDR_W-1:0] home_addr,
  output logic              is_setup,
  output logic              is_confirm,
  output logic              home_hit,
  output logic              exit_req
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;
  localparam logic [DATA_W-1:0] SETUP_W   = DATA_W'(SETUP_CODE);
  localparam logic [DATA_W-1:0] CONFIRM_W = DATA_W'(CONFIRM_CODE);

  logic same_blk;

  always_comb begin
    same_blk   = (blk_addr == home_addr);
    is_setup   = wr_en && (wr_data == SETUP_W);
    is_confirm = wr_en && (wr_data == CONFIRM_W);
    home_hit   = wr_en && same_blk;
    exit_req   = wr_en && !same_blk && (wr_data == ALL_ONES);
  end
endmodule

// File: rtl/efp_addr_latch.sv
module efp_addr_latch #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (cap_en) addr_q <= addr_in;
  end
endmodule

// File: rtl/efp_fsm.sv
module efp_fsm
  import efp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       sr0,
  input  logic       pec_done,
  input  logic       is_setup,
  input  logic       is_confirm,
  input  logic       home_hit,
  input  logic       exit_req,
  output efp_state_t state_q,
  output logic       cap_en,
  output logic       load_en,
  output logic       dv_q,
  output logic       exit_q,
  output logic       err_q
);
  efp_state_t state_n;
  logic       exit_n;
  logic       err_n;

  always_comb begin
    state_n = state_q;
    exit_n  = exit_q;
    err_n   = err_q;
    cap_en  = 1'b0;
    load_en = 1'b0;
    unique case (state_q)
      ST_READY: begin
        exit_n = 1'b0;
        if (is_setup) begin
          if (sr0) begin
            err_n = 1'b1;
          end else begin
            err_n   = 1'b0;
            cap_en  = 1'b1;
            state_n = ST_SETUP;
          end
        end
      end
      ST_SETUP: begin
        exit_n = 1'b0;
        if (wr_en) begin
          if (is_confirm) begin
            state_n = ST_BUSY;
          end else begin
            state_n = ST_READY;
            err_n   = 1'b1;
          end
        end
      end
      ST_BUSY: begin
        load_en = home_hit;
        if (exit_req) exit_n = 1'b1;
        if (pec_done) state_n = ST_VERIFY;
      end
      ST_VERIFY: begin
        load_en = home_hit;
        if (home_hit) begin
          state_n = ST_BUSY;
        end else if (pec_done && (exit_q || exit_req)) begin
          state_n = ST_READY;
          exit_n  = 1'b0;
        end else if (exit_req) begin
          exit_n = 1'b1;
        end
      end
      default: state_n = ST_READY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_READY;
      exit_q  <= 1'b0;
      err_q   <= 1'b0;
      dv_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      exit_q  <= exit_n;
      err_q   <= err_n;
      dv_q    <= load_en;
    end
  end
endmodule

// File: rtl/efp_seq.sv
module efp_seq
  import efp_pkg::*;
#(
  parameter int          ADDR_W       = 8,
  parameter int          DATA_W       = 16,
  parameter logic [15:0] SETUP_CODE   = 16'h0030,
  parameter logic [15:0] CONFIRM_CODE = 16'h00D0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] blk_addr,
  input  logic              sr0,
  input  logic              pec_done,
  output logic [1:0]        state_o,
  output logic              dv_o,
  output logic [DATA_W-1:0] pdata_o,
  output logic              exit_o,
  output logic              err_o
);
  logic              rst_sync_n;
  logic [ADDR_W-1:0] home_addr;
  logic              is_setup, is_confirm, home_hit, exit_req;
  logic              cap_en, load_en;
  efp_state_t        state_q;
  logic [DATA_W-1:0] pdata_q;

  efp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  efp_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SETUP_CODE(SETUP_CODE), .CONFIRM_CODE(CONFIRM_CODE)
  ) u_dec (
    .wr_en(wr_en), .wr_data(wr_data), .blk_addr(blk_addr),
    .home_addr(home_addr), .is_setup(is_setup), .is_confirm(is_confirm),
    .home_hit(home_hit), .exit_req(exit_req)
  );

  efp_addr_latch #(.ADDR_W(ADDR_W)) u_home (
    .clk(clk), .rst_n(rst_sync_n), .cap_en(cap_en),
    .addr_in(blk_addr), .addr_q(home_addr)
  );

  efp_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .sr0(sr0),
    .pec_done(pec_done), .is_setup(is_setup), .is_confirm(is_confirm),
    .home_hit(home_hit), .exit_req(exit_req), .state_q(state_q),
    .cap_en(cap_en), .load_en(load_en), .dv_q(dv_o),
    .exit_q(exit_o), .err_q(err_o)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  pdata_q <= '0;
    else if (load_en) pdata_q <= wr_data;
  end

  assign pdata_o = pdata_q;
  assign state_o = state_q;
endmodule

// File: rtl/efp_seq_chk.sv
module efp_seq_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] blk_addr,
  input logic [ADDR_W-1:0] home_addr,
  input logic              sr0,
  input logic              pec_done,
  input logic [1:0]        state_o,
  input logic              dv_o,
  input logic              exit_o,
  input logic              err_o
);
  localparam logic [DATA_W-1:0] ONES = '1;
  logic in_mode;
  assign in_mode = state_o[1];

  // R3
  sr0_refuse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_o == 2'd0 && wr_en && wr_data == DATA_W'(16'h0030) && sr0)
      |=> (state_o == 2'd0 && err_o));

  // R5
  dv_source_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_mode && wr_en && blk_addr == home_addr) |=> dv_o);

  // R6
  foreign_ignore_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_mode && wr_en && blk_addr != home_addr && wr_data != ONES && !pec_done)
      |=> ($stable(state_o) && $stable(exit_o) && !dv_o));

  // R7
  exit_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_mode && wr_en && blk_addr != home_addr && wr_data == ONES)
      |=> ((exit_o || state_o == 2'd0) && !dv_o));

  // R8
  busy_done_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_o == 2'd2 && pec_done) |=> state_o == 2'd3);

  // R11
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!in_mode && !wr_en && pec_done) |=> $stable(state_o));
endmodule

bind efp_seq efp_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .wr_en(wr_en), .wr_data(wr_data),
  .blk_addr(blk_addr), .home_addr(home_addr), .sr0(sr0),
  .pec_done(pec_done), .state_o(state_o), .dv_o(dv_o),
  .exit_o(exit_o), .err_o(err_o)
);

// File: tb/test_efp_seq.sv
`timescale 1ns/1ps
module test_efp_seq;
  logic        clk = 1'b0;
  logic        rst_n, wr_en, sr0, pec_done;
  logic [15:0] wr_data;
  logic [7:0]  blk_addr;
  logic [1:0]  state_o;
  logic        dv_o, exit_o, err_o;
  logic [15:0] pdata_o;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  efp_seq i_efp_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .blk_addr(blk_addr), .sr0(sr0), .pec_done(pec_done),
    .state_o(state_o), .dv_o(dv_o), .pdata_o(pdata_o),
    .exit_o(exit_o), .err_o(err_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one cycle of stimulus; outputs are then valid at the returning negedge
  task automatic cyc(logic w, logic [7:0] a, logic [15:0] d, logic done);
    @(negedge clk);
    wr_en = w; blk_addr = a; wr_data = d; pec_done = done;
    @(negedge clk);
    wr_en = 1'b0; pec_done = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 state", state_o, 0);
    chk("R1 dv", dv_o, 0);
    chk("R1 exit", exit_o, 0);
    chk("R1 err", err_o, 0);
  endtask

  task automatic t_sr0_refuse;
    sr0 = 1'b1;
    cyc(1, 8'h05, 16'h0030, 0);
    chk("R3 state", state_o, 0);
    chk("R3 err", err_o, 1);
    sr0 = 1'b0;
  endtask

  task automatic t_enter(logic [7:0] a);
    cyc(1, a, 16'h0030, 0);
    chk("R2 state", state_o, 1);
    chk("R3 err cleared", err_o, 0);
    cyc(0, 0, 0, 1);
    chk("R11 done in setup", state_o, 1);
    cyc(1, a, 16'h00D0, 0);
    chk("R4 confirm", state_o, 2);
  endtask

  task automatic t_stream;
    cyc(1, 8'h05, 16'h1234, 0);
    chk("R5 dv", dv_o, 1);
    chk("R5 data", pdata_o, 16'h1234);
    cyc(0, 0, 0, 0);
    chk("R5 pulse width", dv_o, 0);
    cyc(1, 8'h05, 16'h0030, 0);
    chk("R5 code as data dv", dv_o, 1);
    chk("R5 code as data", pdata_o, 16'h0030);
    chk("R5 state", state_o, 2);
    cyc(1, 8'h06, 16'h5555, 0);
    chk("R6 dv", dv_o, 0);
    chk("R6 state", state_o, 2);
    chk("R6 exit", exit_o, 0);
    chk("R6 data kept", pdata_o, 16'h0030);
    cyc(0, 0, 0, 1);
    chk("R8 verify", state_o, 3);
    cyc(0, 0, 0, 1);
    chk("R10 no exit stays", state_o, 3);
    cyc(1, 8'h05, 16'hABCD, 1);
    chk("R9 back to busy", state_o, 2);
    chk("R9 dv", dv_o, 1);
    chk("R9 data", pdata_o, 16'hABCD);
    cyc(0, 0, 0, 1);
    chk("R8 verify again", state_o, 3);
    cyc(1, 8'h09, 16'hFFFF, 0);
    chk("R7 exit", exit_o, 1);
    chk("R7 dv", dv_o, 0);
    chk("R7 state", state_o, 3);
    cyc(0, 0, 0, 1);
    chk("R10 ready", state_o, 0);
    chk("R10 exit cleared", exit_o, 0);
  endtask

  task automatic t_bad_confirm;
    cyc(1, 8'h03, 16'h0030, 0);
    chk("R2 setup", state_o, 1);
    cyc(1, 8'h03, 16'h1111, 0);
    chk("R4 bad state", state_o, 0);
    chk("R4 bad err", err_o, 1);
  endtask

  task automatic t_idle_done;
    cyc(0, 0, 0, 1);
    chk("R11 done in ready", state_o, 0);
  endtask

  task automatic t_relatch_exit;
    t_enter(8'h03);
    cyc(1, 8'h05, 16'h4444, 0);
    chk("R2 old home ignored", dv_o, 0);
    cyc(1, 8'h03, 16'h7777, 0);
    chk("R2 new home dv", dv_o, 1);
    cyc(1, 8'h07, 16'hFFFF, 0);
    chk("R7 exit in busy", exit_o, 1);
    chk("R7 busy kept", state_o, 2);
    cyc(0, 0, 0, 1);
    chk("R8 verify", state_o, 3);
    cyc(1, 8'h08, 16'hFFFF, 1);
    chk("R10 exit with done", state_o, 0);
    chk("R10 exit low", exit_o, 0);
  endtask

  task automatic t_exit_same_cycle;
    t_enter(8'h02);
    cyc(0, 0, 0, 1);
    chk("R8 verify", state_o, 3);
    cyc(1, 8'h04, 16'hFFFF, 1);
    chk("R10 same cycle exit", state_o, 0);
    chk("R10 same cycle exit flag", exit_o, 0);
    chk("R7 no dv", dv_o, 0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; sr0 = 1'b0; pec_done = 1'b0;
    wr_data = '0; blk_addr = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_sr0_refuse;
    t_enter(8'h05);
    t_stream;
    t_bad_confirm;
    t_idle_done;
    t_relatch_exit;
    t_exit_same_cycle;
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule